// File: doc/BRIEF.md
# Bus Width Access Splitter

This block sits between a CPU load/store port and an external memory bus. Each external chip-select space has a fixed device data width of 8, 16 or 32 bits. The CPU asks for a byte, word or longword, and the splitter turns that request into as many external bus cycles as the target device width needs. On a read it gathers the returned pieces into one right-aligned result. On a write it slices the store data into the pieces the device expects. The CPU only sees a single request and a single ready pulse.

The width of space 0 comes from static mode pins. The widths of spaces 1 to 3 come from a configuration register. The block captures the width when it accepts a request, so that width holds for every cycle of that access. Pieces are ordered big-endian: the lowest address carries the most significant part. An access no wider than the device uses one cycle, and the low address bits pick its byte lanes. Accesses are assumed to be naturally aligned to their size.

Top module: `bus_width_splitter`

## Requirements
- R1: After synchronous reset, `cpu_rdy`, `bus_cyc` and `bus_be` are all low.
- R2: The space is `cpu_addr[15:14]` (with default parameters). Space 0 takes its width code from `space0_mode`. Space s (1..3) takes it from `space_cfg[2s-1:2s-2]`. Width codes are 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. Size codes are 0 = byte, 1 = word, 2 or 3 = longword.
- R3: An access of S bytes to a device of D bytes takes exactly one bus cycle when S <= D, and S/D bus cycles otherwise.
- R4: In a split access, the first bus cycle uses the CPU address, each later cycle adds D to it, and the first cycle carries the most significant piece.
- R5: A device of D bytes uses bus lanes 0..D-1, where lane L is `bus_*data[8L+7:8L]`. The byte at offset j inside an aligned device word travels on lane D-1-j. `bus_be[L]` is set exactly for the lanes the access uses.
- R6: When `cpu_rdy` pulses after a read, `cpu_rdata` holds the accessed bytes right-aligned and zero-extended, with the lowest-address byte most significant.
- R7: `cpu_rdy` is a one-cycle pulse, raised in the cycle after the final bus handshake. It is never high while `bus_cyc` is high.
- R8: While `bus_cyc` is high and `bus_ack` is low, the bus address, data, enables and direction hold steady.
- R9: A `cpu_req` raised while an access is in progress is ignored. It starts no further bus cycle.
- R10: The device width is captured at acceptance. Changes to `space0_mode` or `space_cfg` during an access do not alter its cycle count.
- R11: A request is accepted whenever no access is in progress, including the cycle in which `cpu_rdy` is high. Its first bus cycle is presented in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, sampled when idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | Access size code |
| cpu_addr | input | AW | Byte address; top bits select the space |
| cpu_wdata | input | 32 | Right-aligned write data |
| cpu_rdata | output | 32 | Right-aligned read result |
| cpu_rdy | output | 1 | One-cycle completion pulse |
| space0_mode | input | 2 | Width code of space 0 from mode pins |
| space_cfg | input | 2*(2^SPACE_BITS-1) | Width codes of spaces 1 and up |
| bus_cyc | output | 1 | External bus cycle active |
| bus_we | output | 1 | External cycle direction |
| bus_addr | output | AW | External cycle address |
| bus_wdata | output | 32 | External write data by lane |
| bus_be | output | 4 | Byte lane enables |
| bus_rdata | input | 32 | External read data by lane |
| bus_ack | input | 1 | External cycle completes at this edge |

## Verification
The final bus handshake of one access and the acceptance of the next request can fall in the same cycle. That is the cycle in which `cpu_rdy` is high. The bench provokes this by raising the next request at the very clock edge where it first sees the ready pulse, which happens in most of the randomized accesses. It then requires the new access to show its first bus cycle on the following edge. The new access must still have the right cycle count and addresses, and the result just delivered must match the value computed from the bench's shadow memory.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  // size or width code to log2 of its byte count (codes 2 and 3 both mean four bytes)
  function automatic logic [1:0] code_lg(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/bsplit_width_lookup.sv
module bsplit_width_lookup
  import bsplit_pkg::*;
#(
  parameter int SPACE_BITS = 2
) (
  input  logic [SPACE_BITS-1:0]               space,
  input  logic [1:0]                          mode,
  input  logic [2*((1<<SPACE_BITS)-1)-1:0]    cfg,
  output logic [1:0]                          dev_lg
);
  localparam int SPACES = 1 << SPACE_BITS;

  logic [1:0] lg_tbl [SPACES];

  assign lg_tbl[0] = code_lg(mode);

  generate
    for (genvar s = 1; s < SPACES; s++) begin : g_space
      assign lg_tbl[s] = code_lg(cfg[2*s-1 -: 2]);
    end
  endgenerate

  assign dev_lg = lg_tbl[space];
endmodule

// File: rtl/bsplit_plan.sv
module bsplit_plan
  import bsplit_pkg::*;
(
  input  logic [1:0] size_code,
  input  logic [1:0] dev_lg,
  input  logic [1:0] addr_lo,
  output logic [1:0] piece_lg,
  output logic [1:0] beats_m1,
  output logic [1:0] lane_sh
);
  logic [1:0] s_lg;
  logic [2:0] dev_b;
  logic [2:0] acc_b;
  logic [2:0] off_b;

  always_comb begin
    s_lg  = code_lg(size_code);
    dev_b = 3'd1 << dev_lg;
    acc_b = 3'd1 << s_lg;
    off_b = {1'b0, addr_lo} & (dev_b - 3'd1);
    if (s_lg <= dev_lg) begin
      piece_lg = s_lg;
      beats_m1 = 2'd0;
      lane_sh  = 2'(dev_b - off_b - acc_b);
    end else begin
      piece_lg = dev_lg;
      beats_m1 = 2'((3'd1 << (s_lg - dev_lg)) - 3'd1);
      lane_sh  = 2'd0;
    end
  end
endmodule

// File: rtl/bsplit_lane_pack.sv
module bsplit_lane_pack
  import bsplit_pkg::*;
(
  input  logic [DATA_W-1:0] val,
  input  logic [1:0]        piece_lg,
  input  logic [1:0]        remain,
  input  logic [1:0]        lane_sh,
  output logic [DATA_W-1:0] lane_data,
  output logic [LANES-1:0]  lane_be
);
  logic [3:0]        skip_b;
  logic [5:0]        pbits;
  logic [DATA_W-1:0] pmask;
  logic [DATA_W-1:0] piece;
  logic [4:0]        ones;

  always_comb begin
    skip_b    = {2'b00, remain} << piece_lg;
    pbits     = 6'd8 << piece_lg;
    pmask     = {DATA_W{1'b1}} >> (6'd32 - pbits);
    piece     = (val >> {skip_b, 3'b000}) & pmask;
    lane_data = piece << {lane_sh, 3'b000};
    ones      = (5'd1 << (3'd1 << piece_lg)) - 5'd1;
    lane_be   = ones[3:0] << lane_sh;
  end
endmodule

// File: rtl/bsplit_lane_unpack.sv
module bsplit_lane_unpack
  import bsplit_pkg::*;
(
  input  logic [DATA_W-1:0] rd_lanes,
  input  logic [DATA_W-1:0] acc,
  input  logic [1:0]        piece_lg,
  input  logic [1:0]        lane_sh,
  output logic [DATA_W-1:0] acc_next
);
  logic [5:0]        pbits;
  logic [DATA_W-1:0] pmask;
  logic [DATA_W-1:0] piece;

  always_comb begin
    pbits    = 6'd8 << piece_lg;
    pmask    = {DATA_W{1'b1}} >> (6'd32 - pbits);
    piece    = (rd_lanes >> {lane_sh, 3'b000}) & pmask;
    acc_next = (acc << pbits) | piece;
  end
endmodule

// File: rtl/bus_width_splitter.sv
module bus_width_splitter
  import bsplit_pkg::*;
#(
  parameter int AW         = 16,
  parameter int SPACE_BITS = 2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cpu_req,
  input  logic                               cpu_we,
  input  logic [1:0]                         cpu_size,
  input  logic [AW-1:0]                      cpu_addr,
  input  logic [DATA_W-1:0]                  cpu_wdata,
  output logic [DATA_W-1:0]                  cpu_rdata,
  output logic                               cpu_rdy,
  input  logic [1:0]                         space0_mode,
  input  logic [2*((1<<SPACE_BITS)-1)-1:0]   space_cfg,
  output logic                               bus_cyc,
  output logic                               bus_we,
  output logic [AW-1:0]                      bus_addr,
  output logic [DATA_W-1:0]                  bus_wdata,
  output logic [LANES-1:0]                   bus_be,
  input  logic [DATA_W-1:0]                  bus_rdata,
  input  logic                               bus_ack
);
  logic [SPACE_BITS-1:0] space;
  logic [1:0]            dev_lg;
  logic [1:0]            plan_plg, plan_bm1, plan_sh;

  logic [DATA_W-1:0]     wdata_q, acc_q;
  logic [1:0]            plg_q, sh_q, left_q;

  logic                  accept, step, last;
  logic [DATA_W-1:0]     pk_val, pk_data, acc_next;
  logic [1:0]            pk_plg, pk_rem, pk_sh;
  logic [LANES-1:0]      pk_be;

  assign space = cpu_addr[AW-1 -: SPACE_BITS];

  bsplit_width_lookup #(.SPACE_BITS(SPACE_BITS)) u_lookup (
    .space  (space),
    .mode   (space0_mode),
    .cfg    (space_cfg),
    .dev_lg (dev_lg)
  );

  bsplit_plan u_plan (
    .size_code (cpu_size),
    .dev_lg    (dev_lg),
    .addr_lo   (cpu_addr[1:0]),
    .piece_lg  (plan_plg),
    .beats_m1  (plan_bm1),
    .lane_sh   (plan_sh)
  );

  // bus_cyc doubles as the busy flag: idle exactly when no cycle is presented
  assign accept = cpu_req && !bus_cyc;
  assign step   = bus_cyc && bus_ack;
  assign last   = step && (left_q == 2'd0);

  // the packer serves both the first piece (from CPU inputs) and later pieces (from held state)
  always_comb begin
    if (bus_cyc) begin
      pk_val = wdata_q;
      pk_plg = plg_q;
      pk_rem = left_q - 2'd1;
      pk_sh  = sh_q;
    end else begin
      pk_val = cpu_wdata;
      pk_plg = plan_plg;
      pk_rem = plan_bm1;
      pk_sh  = plan_sh;
    end
  end

  bsplit_lane_pack u_pack (
    .val       (pk_val),
    .piece_lg  (pk_plg),
    .remain    (pk_rem),
    .lane_sh   (pk_sh),
    .lane_data (pk_data),
    .lane_be   (pk_be)
  );

  bsplit_lane_unpack u_unpack (
    .rd_lanes (bus_rdata),
    .acc      (acc_q),
    .piece_lg (plg_q),
    .lane_sh  (sh_q),
    .acc_next (acc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_cyc   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_be    <= '0;
      cpu_rdy   <= 1'b0;
      cpu_rdata <= '0;
      wdata_q   <= '0;
      acc_q     <= '0;
      plg_q     <= '0;
      sh_q      <= '0;
      left_q    <= '0;
    end else begin
      cpu_rdy <= last;
      if (accept) begin
        bus_cyc   <= 1'b1;
        bus_we    <= cpu_we;
        bus_addr  <= cpu_addr;
        bus_wdata <= pk_data;
        bus_be    <= pk_be;
        wdata_q   <= cpu_wdata;
        plg_q     <= plan_plg;
        sh_q      <= plan_sh;
        left_q    <= plan_bm1;
        acc_q     <= '0;
      end else if (step) begin
        acc_q <= acc_next;
        if (last) begin
          bus_cyc <= 1'b0;
          bus_be  <= '0;
          if (!bus_we) cpu_rdata <= acc_next;
        end else begin
          left_q    <= left_q - 2'd1;
          bus_addr  <= bus_addr + (AW'(1) << plg_q);
          bus_wdata <= pk_data;
          bus_be    <= pk_be;
        end
      end
    end
  end
endmodule

// File: rtl/bsplit_checker.sv
module bsplit_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_req,
  input logic          cpu_rdy,
  input logic          bus_cyc,
  input logic          bus_ack,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [3:0]    bus_be
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    bus_cyc && !bus_ack |=> bus_cyc && $stable(bus_addr) && $stable(bus_wdata)
                            && $stable(bus_be) && $stable(bus_we));

  assert_rdy_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    cpu_rdy |=> !cpu_rdy);

  assert_rdy_after_ack_R7: assert property (@(posedge clk) disable iff (rst)
    cpu_rdy |-> $past(bus_cyc && bus_ack));

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
    !(cpu_rdy && bus_cyc));

  assert_lane_count_R5: assert property (@(posedge clk) disable iff (rst)
    bus_cyc |-> ($countones(bus_be) == 1 || $countones(bus_be) == 2
                 || $countones(bus_be) == 4));

  assert_accept_R11: assert property (@(posedge clk) disable iff (rst)
    cpu_req && !bus_cyc |=> bus_cyc);

  assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
    bus_cyc && bus_ack |=> !bus_cyc || (bus_addr != $past(bus_addr)));
endmodule

bind bus_width_splitter bsplit_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_req   (cpu_req),
  .cpu_rdy   (cpu_rdy),
  .bus_cyc   (bus_cyc),
  .bus_ack   (bus_ack),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_be    (bus_be)
);

// File: tb/bus_width_splitter_test.sv
module bus_width_splitter_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        cpu_req, cpu_we;
  logic [1:0]  cpu_size;
  logic [15:0] cpu_addr;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        cpu_rdy;
  logic [1:0]  mode_v;
  logic [5:0]  cfg_v;
  logic        bus_cyc, bus_we;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  bus_be;
  logic        bus_ack;

  int n_tests = 0;
  int n_fail  = 0;
  int nbeats;
  int exp_d;
  int wait_left;
  logic [15:0] log_addr [0:7];
  logic [7:0]  mem      [0:255];
  logic [7:0]  exp_mem  [0:255];
  logic [7:0]  sl_base;

  always #5 clk = ~clk;

  bus_width_splitter uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rdy(cpu_rdy),
    .space0_mode(mode_v), .space_cfg(cfg_v), .bus_cyc(bus_cyc), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int size_bytes(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  function automatic int dev_bytes(input logic [1:0] sp);
    logic [1:0] c;
    case (sp)
      2'd0: c = mode_v;
      2'd1: c = cfg_v[1:0];
      2'd2: c = cfg_v[3:2];
      default: c = cfg_v[5:4];
    endcase
    return size_bytes(c);
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] lo, input int sb);
    logic [31:0] v = '0;
    for (int i = 0; i < sb; i++) v = (v << 8) | {24'd0, exp_mem[8'(lo + 8'(i))]};
    return v;
  endfunction

  // bus slave: decides at each falling edge whether the presented cycle completes
  always @(negedge clk) begin
    if (rst) begin
      bus_ack   = 1'b0;
      wait_left = 0;
      bus_rdata = '0;
    end else if (bus_cyc) begin
      if (wait_left == 0) begin
        sl_base = bus_addr[7:0] & ~8'(exp_d - 1);
        if (nbeats < 8) log_addr[nbeats] = bus_addr;
        nbeats++;
        for (int l = 0; l < 4; l++) begin
          if (l < exp_d) begin
            if (bus_we && bus_be[l]) mem[8'(sl_base + 8'(exp_d - 1 - l))] = bus_wdata[8*l +: 8];
            bus_rdata[8*l +: 8] = mem[8'(sl_base + 8'(exp_d - 1 - l))];
          end else begin
            bus_rdata[8*l +: 8] = 8'($urandom);
          end
        end
        bus_ack   = 1'b1;
        wait_left = $urandom_range(2, 0);
      end else begin
        wait_left--;
        bus_ack = 1'b0;
      end
    end else begin
      bus_ack = 1'b0;
    end
  end

  task automatic run(input logic we, input logic [1:0] sz, input logic [1:0] sp,
                     input logic [7:0] lo, input logic [31:0] wd, input string tag,
                     input bit poke_busy, input bit poke_cfg);
    int sb, db, eb;
    logic [15:0] a;
    logic [31:0] ev;
    sb = size_bytes(sz);
    db = dev_bytes(sp);
    a  = {sp, 6'd0, lo & ~8'(sb - 1)};
    exp_d  = db;
    nbeats = 0;
    ev = '0;
    if (!we) ev = exp_read(a[7:0], sb);
    else for (int i = 0; i < sb; i++) exp_mem[8'(a[7:0] + 8'(i))] = wd[8*(sb-1-i) +: 8];
    cpu_req = 1'b1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    chk(bus_cyc == 1'b1, "R11 first cycle after accept", {31'd0, bus_cyc}, 32'd1);
    if (poke_busy) begin
      cpu_req = 1'b1; cpu_we = ~we; cpu_size = 2'd2; cpu_addr = ~a; cpu_wdata = ~wd;
    end else begin
      cpu_req = 1'b0; cpu_addr = 16'($urandom); cpu_wdata = $urandom; cpu_size = 2'($urandom);
    end
    if (poke_cfg) begin mode_v = ~mode_v; cfg_v = ~cfg_v; end
    while (!cpu_rdy) begin
      @(negedge clk);
      cpu_req = 1'b0;
    end
    cpu_req = 1'b0;
    eb = (sb > db) ? sb / db : 1;
    chk(nbeats == eb, tag, 32'(nbeats), 32'(eb));
    chk(bus_cyc == 1'b0, "R7 bus idle with ready", {31'd0, bus_cyc}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      if (i < nbeats && i < eb) begin
        logic [15:0] ea;
        ea = (sb > db) ? a + 16'(i * db) : a;
        chk(log_addr[i] == ea, "R4 cycle address", {16'd0, log_addr[i]}, {16'd0, ea});
      end
    end
    if (!we) begin
      chk(cpu_rdata == ev, "R6 read result", cpu_rdata, ev);
    end else begin
      for (int j = 0; j < 4; j++) begin
        logic [7:0] ix;
        ix = (a[7:0] & 8'hFC) + 8'(j);
        chk(mem[ix] == exp_mem[ix], "R5 written bytes", {24'd0, mem[ix]}, {24'd0, exp_mem[ix]});
      end
    end
    if (poke_busy) begin
      @(negedge clk);
      chk(!bus_cyc && !cpu_rdy, "R9 busy request ignored", {30'd0, bus_cyc, cpu_rdy}, 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd99));
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 8'(i * 37 + 17);
      exp_mem[i] = 8'(i * 37 + 17);
    end
    rst = 1'b1; cpu_req = 1'b0; cpu_we = 1'b0; cpu_size = 2'd0;
    cpu_addr = '0; cpu_wdata = '0;
    mode_v = 2'd0;         // space0 8-bit
    cfg_v  = 6'b111001;    // space1 16-bit, space2 32-bit, space3 code 3 (32-bit)
    nbeats = 0; exp_d = 4;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!cpu_rdy && !bus_cyc, "R1 reset controls", {30'd0, cpu_rdy, bus_cyc}, 32'd0);
    chk(bus_be == 4'd0, "R1 reset lane enables", {28'd0, bus_be}, 32'd0);

    // directed corners
    run(1'b0, 2'd2, 2'd0, 8'h10, 32'd0,        "R3 long read on 8-bit", 1'b0, 1'b0);
    run(1'b1, 2'd2, 2'd0, 8'h20, 32'hA1B2C3D4, "R4 long write on 8-bit", 1'b0, 1'b0);
    run(1'b0, 2'd2, 2'd0, 8'h20, 32'd0,        "R6 long readback on 8-bit", 1'b0, 1'b0);
    run(1'b1, 2'd1, 2'd0, 8'h32, 32'h0000BEEF, "R3 word write on 8-bit", 1'b0, 1'b0);
    run(1'b0, 2'd2, 2'd1, 8'h44, 32'd0,        "R3 long read on 16-bit", 1'b0, 1'b0);
    run(1'b1, 2'd2, 2'd1, 8'h48, 32'h11223344, "R3 long write on 16-bit", 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      run(1'b1, 2'd0, 2'd2, 8'(8'h60 + k), 32'(8'hC0 + k), "R5 byte write on 32-bit", 1'b0, 1'b0);
      run(1'b0, 2'd0, 2'd2, 8'(8'h70 + k), 32'd0,          "R5 byte read on 32-bit", 1'b0, 1'b0);
    end
    run(1'b1, 2'd1, 2'd2, 8'h82, 32'h00005A6B, "R5 word write upper half", 1'b0, 1'b0);
    run(1'b0, 2'd1, 2'd2, 8'h80, 32'd0,        "R5 word read lower offset", 1'b0, 1'b0);
    run(1'b0, 2'd0, 2'd1, 8'h91, 32'd0,        "R5 byte read on 16-bit", 1'b0, 1'b0);
    run(1'b0, 2'd3, 2'd3, 8'hA4, 32'd0,        "R2 size code 3 on width code 3", 1'b0, 1'b0);
    run(1'b1, 2'd3, 2'd0, 8'hB0, 32'h5566AA77, "R2 size code 3 on 8-bit", 1'b0, 1'b0);
    run(1'b0, 2'd2, 2'd0, 8'hC0, 32'd0,        "R3 split with busy request", 1'b1, 1'b0);
    run(1'b0, 2'd2, 2'd0, 8'hC8, 32'd0,        "R10 width change mid access", 1'b0, 1'b1);
    mode_v = 2'd0; cfg_v = 6'b111001;

    // constrained random, mostly back to back
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(9, 0) == 0) begin
        mode_v = 2'($urandom);
        cfg_v  = 6'($urandom);
      end
      run(1'($urandom), 2'($urandom), 2'($urandom), 8'($urandom), $urandom,
          "R3 random cycle count", 1'b0, 1'b0);
      if ($urandom_range(3, 0) == 0) begin
        @(negedge clk);
        chk(!cpu_rdy && !bus_cyc, "R7 ready lasts one cycle", {30'd0, cpu_rdy, bus_cyc}, 32'd0);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule